// File: doc/BRIEF.md
# Primary Clock Failure Monitor with Automatic Switchover

This block supervises an external primary oscillator and decides which of two sources drives the system clock. It runs only from an internal oscillator that never stops. A toggle flop on the primary clock is brought into the internal domain through a synchronizer, and a divider of the internal clock makes a slow sample tick. If a whole sample window passes with no primary edge, the block enters a fail-safe mode. In that mode it raises a sticky failure flag and moves clock selection to the internal source.

After reset, the system runs on the internal clock until the primary source says it is ready. The block then switches to the primary clock, sets a status bit and starts monitoring. Monitoring is off while the primary is still starting, so a slow start-up is never reported as a failure. The fail-safe mode ends only through reset or a power-managed-mode entry strobe. A primary clock that comes back on its own does not end it. On exit the start-up sequence runs again, and monitoring resumes once the primary is selected again. The clock-select output is a level for an external glitch-free clock multiplexer.

Top module: `clk_failsafe_monitor`

## Requirements
- R1: During and right after reset, `mode_state` is 0 (start-up on internal clock), and `clk_sel`, `pri_active` and `fail_flag` are 0. Mode codes: 0 start-up, 1 running on primary, 2 fail-safe. `clk_sel` encoding: 0 internal, 1 primary.
- R2: While `pri_ready` is low the block stays in mode 0 for any length of time, whether the primary clock is toggling or dead, and it never sets `fail_flag`.
- R3: When `pri_ready` is high in mode 0, the mode becomes 1 on the next clock edge. `clk_sel` and `pri_active` go to 1 one edge after that.
- R4: `clk_sel` never changes on the same edge as `mode_state`. It follows each mode change exactly one internal cycle later.
- R5: In mode 1, a primary clock whose period is at most one sample window (`SAMPLE_DIV` internal cycles) never causes a failure.
- R6: In mode 1, a sample window with no primary rising edge moves the mode to 2. The first tick after monitoring starts only arms the check. A stopped primary is caught within 3·`SAMPLE_DIV` cycles. One cycle after entering mode 2, `clk_sel` and `pri_active` are 0.
- R7: `fail_flag` is set on the edge that enters mode 2. It stays set until a one-cycle `flag_clr` pulse clears it, and clearing does not change the mode.
- R8: Mode 2 is left only by reset or by `pm_enter`, and `pm_enter` is honoured once `clk_sel` has reached 0. Leaving goes to mode 0. A restarted primary clock or toggling `pri_ready` has no effect while in mode 2.
- R9: `pm_enter` has no effect in modes 0 and 1.
- R10: After leaving mode 2 and returning to mode 1, monitoring works again, and a second primary stop is detected as a new failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Always-running internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pri | input | 1 | Primary oscillator clock being watched |
| pri_ready | input | 1 | Primary source start-up complete (internal domain) |
| pm_enter | input | 1 | One-cycle strobe: entry into a power-managed mode |
| flag_clr | input | 1 | One-cycle strobe clearing the failure flag |
| clk_sel | output | 1 | System clock select: 0 internal, 1 primary |
| pri_active | output | 1 | Status: system has switched to the primary clock |
| fail_flag | output | 1 | Sticky failure interrupt flag |
| mode_state | output | 2 | Current mode: 0 start-up, 1 primary run, 2 fail-safe |

## Verification
The bench derives the primary clock from a counter, so each half period is a whole number of internal cycles. Half periods of 1 to 4 cycles (periods up to the 8-cycle window) must never trip the monitor. A stopped clock and half periods of 8, 12 and 16 cycles must trip it, which separates a window that holds an edge from a window that does not. A dead and a toggling primary are both held in start-up with `pri_ready` low, which shows that monitoring is suspended. A restarted primary with `pri_ready` toggled in fail-safe shows that only the power-managed strobe exits. Exact-cycle samples around each mode change show the one-cycle lag of clock select.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        MODE_STARTUP  = 2'd0,
        MODE_RUN      = 2'd1,
        MODE_FAILSAFE = 2'd2
    } mode_e;

    typedef struct packed {
        logic tick;
        logic pri_edge;
        logic fail;
    } mon_evt_t;

    function automatic logic primary_selected(mode_e m);
        return (m == MODE_RUN);
    endfunction

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_int,
    input  logic rst,
    input  logic clk_pri,
    output logic pri_edge
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic tog = 1'b0;
    logic [SH_W-1:0] sh;

    // Toggle flop in the primary domain; each primary rising edge flips it.
    always_ff @(posedge clk_pri) begin
        tog <= ~tog;
    end

    // Synchronizer chain plus one history stage for change detection.
    always_ff @(posedge clk_int) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], tog};
    end

    assign pri_edge = sh[SH_W-1] ^ sh[SH_W-2];
endmodule

// File: rtl/clkmon_tick_div.sv
module clkmon_tick_div #(
    parameter int SAMPLE_DIV = 64
) (
    input  logic clk_int,
    input  logic rst,
    output logic tick
);
    localparam int CW = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk_int) begin
        if (rst)               cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/clkmon_activity.sv
module clkmon_activity (
    input  logic clk_int,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic pri_edge,
    output logic fail
);
    logic seen;
    logic armed;

    // An edge in the tick cycle counts toward the next window.
    always_ff @(posedge clk_int) begin
        if (rst || !enable) begin
            seen  <= 1'b0;
            armed <= 1'b0;
        end else if (tick) begin
            seen  <= pri_edge;
            armed <= 1'b1;
        end else begin
            seen  <= seen | pri_edge;
        end
    end

    assign fail = enable & tick & armed & ~seen;
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
    import clkmon_pkg::*;
(
    input  logic  clk_int,
    input  logic  rst,
    input  logic  pri_ready,
    input  logic  pm_enter,
    input  logic  flag_clr,
    input  logic  fail,
    output mode_e mode_q,
    output logic  sel_q,
    output logic  stat_q,
    output logic  flag_q,
    output logic  mon_en
);
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_STARTUP:  if (pri_ready)           mode_d = MODE_RUN;
            MODE_RUN:      if (fail)                mode_d = MODE_FAILSAFE;
            MODE_FAILSAFE: if (pm_enter && !sel_q)  mode_d = MODE_STARTUP;
            default:                                mode_d = MODE_STARTUP;
        endcase
    end

    always_ff @(posedge clk_int) begin
        if (rst) begin
            mode_q <= MODE_STARTUP;
            sel_q  <= 1'b0;
            stat_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            sel_q  <= primary_selected(mode_q);
            stat_q <= primary_selected(mode_q);
            if (mode_q == MODE_RUN && fail) flag_q <= 1'b1;
            else if (flag_clr)              flag_q <= 1'b0;
        end
    end

    assign mon_en = (mode_q == MODE_RUN);

    // R4: select is steady on any edge where the mode moves
    p_sel_lag_r4: assert property (@(posedge clk_int) disable iff (rst)
        (mode_q != $past(mode_q)) |-> (sel_q == $past(sel_q)));

    // R6: after one cycle in fail-safe the internal clock is selected
    p_failsafe_internal_r6: assert property (@(posedge clk_int) disable iff (rst)
        (mode_q == MODE_FAILSAFE && $past(mode_q) == MODE_FAILSAFE) |-> !sel_q);

    // R7: entering fail-safe raises the flag
    p_flag_on_entry_r7: assert property (@(posedge clk_int) disable iff (rst)
        (mode_q == MODE_FAILSAFE && $past(mode_q) == MODE_RUN) |-> flag_q);

    // R8: fail-safe persists without the power-managed strobe
    p_failsafe_sticky_r8: assert property (@(posedge clk_int) disable iff (rst)
        (mode_q == MODE_FAILSAFE && !pm_enter) |=> (mode_q == MODE_FAILSAFE));

    // R2: start-up without ready holds
    p_startup_hold_r2: assert property (@(posedge clk_int) disable iff (rst)
        (mode_q == MODE_STARTUP && !pri_ready) |=> (mode_q == MODE_STARTUP));

    // R2: no flag can appear while the primary is not being monitored
    p_flag_quiet_r2: assert property (@(posedge clk_int) disable iff (rst)
        (mode_q != MODE_RUN && !flag_q) |=> !flag_q);
endmodule

// File: rtl/clk_failsafe_monitor.sv
module clk_failsafe_monitor
    import clkmon_pkg::*;
#(
    parameter int SAMPLE_DIV  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_int,
    input  logic       rst,
    input  logic       clk_pri,
    input  logic       pri_ready,
    input  logic       pm_enter,
    input  logic       flag_clr,
    output logic       clk_sel,
    output logic       pri_active,
    output logic       fail_flag,
    output logic [1:0] mode_state
);
    mon_evt_t evt;
    mode_e    mode_q;
    logic     mon_en;

    clkmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_int (clk_int),
        .rst     (rst),
        .clk_pri (clk_pri),
        .pri_edge(evt.pri_edge)
    );

    clkmon_tick_div #(.SAMPLE_DIV(SAMPLE_DIV)) u_div (
        .clk_int(clk_int),
        .rst    (rst),
        .tick   (evt.tick)
    );

    clkmon_activity u_act (
        .clk_int (clk_int),
        .rst     (rst),
        .enable  (mon_en),
        .tick    (evt.tick),
        .pri_edge(evt.pri_edge),
        .fail    (evt.fail)
    );

    clkmon_ctrl u_ctrl (
        .clk_int  (clk_int),
        .rst      (rst),
        .pri_ready(pri_ready),
        .pm_enter (pm_enter),
        .flag_clr (flag_clr),
        .fail     (evt.fail),
        .mode_q   (mode_q),
        .sel_q    (clk_sel),
        .stat_q   (pri_active),
        .flag_q   (fail_flag),
        .mon_en   (mon_en)
    );

    assign mode_state = mode_q;
endmodule

// File: tb/clk_failsafe_monitor_bench.sv
module clk_failsafe_monitor_bench;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pclk = 1'b0;
    logic pri_ready = 1'b0;
    logic pm_enter = 1'b0;
    logic flag_clr = 1'b0;
    logic clk_sel, pri_active, fail_flag;
    logic [1:0] mode_state;

    int total = 0;
    int bad = 0;
    int pk = 0;
    int pc = 0;

    always #10 clk = ~clk;

    // Primary clock: toggles every pk internal cycles, stopped when pk == 0
    always @(negedge clk) begin
        if (pk > 0) begin
            pc = pc + 1;
            if (pc >= pk) begin
                pc = 0;
                pclk = ~pclk;
            end
        end else begin
            pc = 0;
        end
    end

    clk_failsafe_monitor #(.SAMPLE_DIV(DIV), .SYNC_STAGES(2)) u_clk_failsafe_monitor (
        .clk_int   (clk),
        .rst       (rst),
        .clk_pri   (pclk),
        .pri_ready (pri_ready),
        .pm_enter  (pm_enter),
        .flag_clr  (flag_clr),
        .clk_sel   (clk_sel),
        .pri_active(pri_active),
        .fail_flag (fail_flag),
        .mode_state(mode_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Waits up to n cycles for a mode; returns cycles used or -1
    task automatic wait_mode(input int m, input int n, output int used);
        used = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mode_state == 2'(m)) begin
                used = i;
                break;
            end
        end
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int used;
        int left;
        // R1: reset state
        cyc(2);
        check(mode_state == 2'd0 && !clk_sel && !pri_active && !fail_flag, "R1 during reset",
              int'(mode_state), 0);
        do_reset();
        check(mode_state == 2'd0, "R1 mode", int'(mode_state), 0);
        check(!clk_sel && !pri_active, "R1 select/status", int'(clk_sel), 0);
        check(!fail_flag, "R1 flag", int'(fail_flag), 0);

        // R2: not ready, dead primary then toggling primary
        pk = 0;
        cyc(10 * DIV);
        check(mode_state == 2'd0 && !fail_flag, "R2 dead primary held", int'(mode_state), 0);
        pk = 3;
        cyc(10 * DIV);
        check(mode_state == 2'd0 && !fail_flag && !clk_sel, "R2 running primary held",
              int'(mode_state), 0);
        pm_enter = 1'b1;
        @(negedge clk);
        pm_enter = 1'b0;
        check(mode_state == 2'd0, "R9 strobe in start-up", int'(mode_state), 0);

        // R3/R4: switch to primary
        pk = 2;
        pri_ready = 1'b1;
        @(negedge clk);
        check(mode_state == 2'd1, "R3 mode next cycle", int'(mode_state), 1);
        check(!clk_sel, "R4 select lags mode", int'(clk_sel), 0);
        @(negedge clk);
        check(clk_sel && pri_active, "R3 select and status", int'(clk_sel), 1);

        // R5: healthy primary
        left = 0;
        for (int i = 0; i < 10 * DIV; i++) begin
            @(negedge clk);
            if (mode_state != 2'd1) left++;
        end
        check(left == 0, "R5 no false failure", left, 0);

        // R9: strobe while running
        pm_enter = 1'b1;
        @(negedge clk);
        pm_enter = 1'b0;
        @(negedge clk);
        check(mode_state == 2'd1 && clk_sel, "R9 strobe in run", int'(mode_state), 1);

        // R6/R7: primary stops
        pk = 0;
        wait_mode(2, 3 * DIV, used);
        check(used >= 0, "R6 stop detected", used, 0);
        check(fail_flag, "R7 flag on entry", int'(fail_flag), 1);
        check(clk_sel, "R4 select steady at transition", int'(clk_sel), 1);
        @(negedge clk);
        check(!clk_sel && !pri_active, "R6 internal select", int'(clk_sel), 0);

        // R8: restart primary and toggle ready: stays in fail-safe
        pk = 2;
        pri_ready = 1'b0;
        cyc(2 * DIV);
        pri_ready = 1'b1;
        cyc(3 * DIV);
        check(mode_state == 2'd2 && !clk_sel, "R8 primary return ignored", int'(mode_state), 2);
        check(fail_flag, "R7 flag sticky", int'(fail_flag), 1);

        // R7: clear flag
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(!fail_flag, "R7 flag cleared", int'(fail_flag), 0);
        check(mode_state == 2'd2, "R7 clear keeps mode", int'(mode_state), 2);

        // R8/R10: exit via power-managed entry, then re-monitor
        pm_enter = 1'b1;
        @(negedge clk);
        pm_enter = 1'b0;
        check(mode_state == 2'd0, "R8 exit to start-up", int'(mode_state), 0);
        @(negedge clk);
        check(mode_state == 2'd1, "R10 back to run", int'(mode_state), 1);
        cyc(5 * DIV);
        check(mode_state == 2'd1 && !fail_flag, "R10 healthy after return", int'(mode_state), 1);
        pk = 0;
        wait_mode(2, 3 * DIV, used);
        check(used >= 0 && fail_flag, "R10 second failure", used, 0);

        // R5 sweep: period up to one window never fails
        for (int k = 1; k <= 4; k++) begin
            pk = k;
            pri_ready = 1'b0;
            do_reset();
            pri_ready = 1'b1;
            left = 0;
            for (int i = 0; i < 20 * DIV; i++) begin
                @(negedge clk);
                if (mode_state != 2'd1 && i > 0) left++;
            end
            check(left == 0 && !fail_flag, $sformatf("R5 sweep half=%0d", k), left, 0);
        end

        // R6 sweep: period of two windows or more must fail
        for (int k = 8; k <= 16; k += 4) begin
            pk = k;
            pri_ready = 1'b0;
            do_reset();
            pri_ready = 1'b1;
            wait_mode(2, 2 * k + 4 * DIV, used);
            check(used >= 0 && fail_flag, $sformatf("R6 sweep half=%0d", k), used, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule